// File: doc/BRIEF.md
# I2C SCL timing divider encoder

This block turns a requested ratio between the peripheral clock and the wanted I2C clock into a packed timing word. That word holds a power-of-two prescaler exponent and two 4-bit phase counts. The block then uses the same values to drive an SCL waveform. The ratio is reduced one halving per clock until it fits in four bits. Every bit dropped along the way is remembered in a sticky flag, and the flag rounds the reduced ratio up, so the generated SCL period is never shorter than the one requested.

A load strobe captures the ratio and a target frequency in kHz. When the reduction ends, `done_o` rises and several things become valid: the packed word, a second "auxiliary" timing word that flags fast operation, a base tick every 2^exponent clocks, and the SCL waveform. A new load at any time aborts the computation or the waveform in progress and starts over.

Top module: `scl_timing_gen`

## Requirements
- R1: A high `load_i` at a clock edge captures `ratio_i` and `target_khz_i`, and `done_o` is low after that edge. A load during a computation or while SCL is running restarts the block: `done_o` stays low, `scl_o` is high and `word_o` is zero until the new result is ready.
- R2: While the held ratio is 16 or more, it is halved once per clock and the exponent grows by one. If k halvings are needed, `done_o` rises exactly k+1 clock edges after the load edge.
- R3: The reduced ratio is the final value below 16 plus a round-up bit. The round-up bit is the OR of all the bits shifted out.
- R4: The low count is (reduced >> 1) - 1 and the high count is reduced - low - 2. Both are taken modulo 16.
- R5: While `done_o` is high, `word_o` = 0x77700300 OR (high << 16) OR (low << 12) OR (exponent mod 16). The high count sits in bits 19:16, the low count in bits 15:12 and the exponent in bits 3:0. While `done_o` is low, `word_o` is zero.
- R6: `aux_word_o` is 3 when the effective target exceeds 400 kHz and 0 otherwise. A target of 0 stands for 100 kHz.
- R7: While `done_o` is high, `tick_o` is a one-cycle pulse once every 2^exponent clocks. The first pulse comes 2^exponent cycles after `done_o` rises.
- R8: `scl_o` is high while `done_o` is low. It goes low in the cycle `done_o` rises and stays low for (low+1)·2^exponent cycles. It then stays high for (high+1)·2^exponent cycles. SCL changes level only after a tick.
- R9: After reset, `done_o`, `word_o`, `aux_word_o` and `tick_o` are zero and `scl_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 32 | Requested peripheral-to-SCL clock ratio |
| target_khz_i | input | 16 | Target SCL frequency in kHz, 0 = default 100 |
| load_i | input | 1 | Start strobe, captures the inputs |
| done_o | output | 1 | Result valid, SCL running |
| word_o | output | 32 | Packed timing word |
| aux_word_o | output | 32 | Second timing word (3 = fast, 0 = no timeout) |
| tick_o | output | 1 | Base-clock tick |
| scl_o | output | 1 | Generated SCL level |

## Verification
Two cases are hard to reach: a load that lands in the middle of the halving sequence, and the wrap-around counts that ratios 0 and 1 produce. To hit the first, the bench issues a large ratio and reloads two cycles later. It then checks that no stale result appears and that the restart latency counts from the second strobe. Ratios 0, 1, 16, 17 and 31 sit on the round-up and modulo-16 edges. For each of these the scoreboard measures the whole low and high SCL phases and the tick count, and compares them with values computed from the requirements.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FIELD_W   = 4;
  localparam int unsigned FIT_LIMIT = 16;
  localparam int unsigned HI_LSB    = 16;
  localparam int unsigned LO_LSB    = 12;
  localparam int unsigned EXP_LSB   = 0;
  localparam logic [WORD_W-1:0] FIXED_BITS = 32'h7770_0300;
  localparam logic [WORD_W-1:0] FIELD_MASK = 32'h000F_F00F;
  localparam logic [WORD_W-1:0] FAST_AUX   = 32'h0000_0003;
endpackage

// File: rtl/ratio_reducer.sv
module ratio_reducer import scl_div_pkg::*; #(
  parameter int unsigned RATIO_W = 32,
  parameter int unsigned EXP_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               done_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic [FIELD_W:0]   red_o
);
  logic [RATIO_W-1:0] r_q;
  logic [EXP_W-1:0]   exp_q;
  logic               sticky_q, busy_q, done_q;
  logic               fits;

  assign fits = (r_q < RATIO_W'(FIT_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0; exp_q <= '0; sticky_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (load_i) begin
      r_q <= ratio_i; exp_q <= '0; sticky_q <= 1'b0; busy_q <= 1'b1; done_q <= 1'b0;
    end else if (busy_q) begin
      if (!fits) begin
        r_q      <= r_q >> 1;
        sticky_q <= sticky_q | r_q[0];
        exp_q    <= exp_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // round up by the sticky bit
  assign red_o  = {1'b0, r_q[FIELD_W-1:0]} + {{FIELD_W{1'b0}}, sticky_q};
  assign exp_o  = exp_q;
  assign done_o = done_q;

  p_halve_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !load_i && !fits |=> exp_q == $past(exp_q) + 1'b1);
  p_fit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (fits && red_o <= (FIELD_W+1)'(FIT_LIMIT)));
  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
endmodule

// File: rtl/timing_packer.sv
module timing_packer import scl_div_pkg::*; (
  input  logic [FIELD_W:0]   red_i,
  input  logic [FIELD_W-1:0] exp_i,
  output logic [FIELD_W-1:0] lo_o,
  output logic [FIELD_W-1:0] hi_o,
  output logic [WORD_W-1:0]  word_o
);
  logic [FIELD_W-1:0] half;

  always_comb begin
    half   = red_i[FIELD_W:1];
    lo_o   = half - FIELD_W'(1);
    hi_o   = red_i[FIELD_W-1:0] - lo_o - FIELD_W'(2);  // modulo 16
    word_o = FIXED_BITS
           | (WORD_W'(hi_o)  << HI_LSB)
           | (WORD_W'(lo_o)  << LO_LSB)
           | (WORD_W'(exp_i) << EXP_LSB);
  end
endmodule

// File: rtl/scl_wave.sv
module scl_wave import scl_div_pkg::*; #(
  parameter int unsigned PRE_W = 32,
  parameter int unsigned EXP_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [FIELD_W-1:0] lo_i,
  input  logic [FIELD_W-1:0] hi_i,
  output logic               tick_o,
  output logic               scl_o
);
  logic [PRE_W-1:0]   cnt_q, lim;
  logic [FIELD_W-1:0] ph_q, target;
  logic               lvl_q, tick;

  assign lim    = (PRE_W'(1) << exp_i) - PRE_W'(1);
  assign tick   = run_i && (cnt_q == lim);
  assign target = lvl_q ? hi_i : lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; ph_q <= '0; lvl_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0; ph_q <= '0; lvl_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        if (ph_q == target) begin
          ph_q  <= '0;
          lvl_q <= ~lvl_q;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick;
  assign scl_o  = run_i ? lvl_q : 1'b1;

  p_toggle_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && (scl_o != $past(scl_o)) |-> $past(tick_o));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim);
  p_ph_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ph_q <= target);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen import scl_div_pkg::*; #(
  parameter int unsigned RATIO_W        = 32,
  parameter int unsigned KHZ_W          = 16,
  parameter int unsigned FAST_LIMIT_KHZ = 400,
  parameter int unsigned DEFAULT_KHZ    = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [KHZ_W-1:0]   target_khz_i,
  input  logic               load_i,
  output logic               done_o,
  output logic [WORD_W-1:0]  word_o,
  output logic [WORD_W-1:0]  aux_word_o,
  output logic               tick_o,
  output logic               scl_o
);
  localparam int unsigned EXP_W = $clog2(RATIO_W);

  logic               done;
  logic [EXP_W-1:0]   exp_v;
  logic [FIELD_W:0]   red;
  logic [FIELD_W-1:0] lo, hi;
  logic [WORD_W-1:0]  packed_word, aux_q;
  logic [KHZ_W-1:0]   eff_khz;

  ratio_reducer #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) i_reducer (
    .clk_i, .rst_ni, .load_i, .ratio_i,
    .done_o(done), .exp_o(exp_v), .red_o(red)
  );

  timing_packer i_packer (
    .red_i(red), .exp_i(exp_v[FIELD_W-1:0]),
    .lo_o(lo), .hi_o(hi), .word_o(packed_word)
  );

  scl_wave #(.PRE_W(RATIO_W), .EXP_W(EXP_W)) i_wave (
    .clk_i, .rst_ni, .run_i(done), .exp_i(exp_v),
    .lo_i(lo), .hi_i(hi), .tick_o, .scl_o
  );

  assign eff_khz = (target_khz_i == '0) ? KHZ_W'(DEFAULT_KHZ) : target_khz_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     aux_q <= '0;
    else if (load_i) aux_q <= (eff_khz > KHZ_W'(FAST_LIMIT_KHZ)) ? FAST_AUX : '0;
  end

  assign done_o     = done;
  assign word_o     = done ? packed_word : '0;
  assign aux_word_o = aux_q;

  p_load_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o && scl_o && !tick_o);
  p_word_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (word_o & ~FIELD_MASK) == FIXED_BITS);
  p_aux_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(aux_word_o));
  p_done_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o && $stable(word_o));
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ratio = '0;
  logic [15:0] khz = '0;
  logic        load = 1'b0;
  logic        done, tick, scl;
  logic [31:0] word, aux;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int unsigned word; int unsigned aux;
    int unsigned low_cyc; int unsigned high_cyc; int unsigned ticks;
  } exp_t;
  exp_t sb_q[$];
  bit   mon_busy = 1'b0;

  always #2.5 clk = ~clk;

  scl_timing_gen i_scl_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .target_khz_i(khz),
    .load_i(load), .done_o(done), .word_o(word), .aux_word_o(aux),
    .tick_o(tick), .scl_o(scl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // expected values from the requirements
  function automatic exp_t model(input int unsigned rv, input int unsigned kv,
                                 output int unsigned steps);
    exp_t e;
    int unsigned r = rv, s = 0, k = 0, lo, hi, eff;
    while (r >= 16) begin s |= r & 1; r >>= 1; k++; end
    r += s;
    lo = ((r >> 1) - 1) & 15;
    hi = (r - lo - 2) & 15;
    e.word = 32'h7770_0300 | (hi << 16) | (lo << 12) | (k & 15);
    eff = (kv == 0) ? 100 : kv;
    e.aux = (eff > 400) ? 3 : 0;
    e.low_cyc = (lo + 1) << k;
    e.high_cyc = (hi + 1) << k;
    e.ticks = lo + 1;
    steps = k;
    return e;
  endfunction

  task automatic pulse_load(input int unsigned rv, input int unsigned kv);
    @(negedge clk);
    ratio = rv; khz = kv[15:0]; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_case(input int unsigned rv, input int unsigned kv);
    int unsigned k;
    int unsigned j;
    exp_t e;
    e = model(rv, kv, k);
    sb_q.push_back(e);
    mon_busy = 1'b1;
    pulse_load(rv, kv);
    chk(!done && scl && word == 0, "R1", "state after load", {done, scl}, 2'b01);
    j = 0;
    while (!done) begin @(negedge clk); j++; end
    chk(j == k + 1, "R2", $sformatf("latency ratio %0d", rv), j, k + 1);
    while (mon_busy) @(negedge clk);
  endtask

  // monitor: pops expected items when a result appears
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !prev) begin
        exp_t e;
        int unsigned lc, hc, tc;
        e = sb_q.pop_front();
        chk(word == e.word, "R5", "packed word", word, e.word);
        chk(aux == e.aux, "R6", "aux word", aux, e.aux);
        lc = 0; tc = 0;
        while (done && !scl) begin
          lc++; if (tick) tc++; @(negedge clk);
        end
        hc = 0;
        while (done && scl) begin hc++; @(negedge clk); end
        chk(lc == e.low_cyc, "R8", "low phase cycles", lc, e.low_cyc);
        chk(hc == e.high_cyc, "R8", "high phase cycles", hc, e.high_cyc);
        chk(tc == e.ticks, "R7", "ticks in low phase", tc, e.ticks);
        mon_busy = 1'b0;
      end
      prev = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && word == 0 && aux == 0 && !tick && scl, "R9", "reset state",
        {done, tick, scl}, 3'b001);
    run_case(100, 0);    // R3 round-up from sticky bit
    run_case(2, 100);    // R4 minimal counts
    run_case(15, 400);   // R6 limit not fast
    run_case(16, 401);   // R6 fast
    run_case(17, 1000);  // R3 sticky from last bit
    run_case(31, 0);     // R3 reduced ratio reaches 16
    run_case(1, 0);      // R4 modulo-16 wrap
    run_case(0, 0);      // R4 modulo-16 wrap
    run_case(256, 50);
    run_case(1000, 400);
    // R1 reload during the halving sequence
    pulse_load(3000, 1000);
    @(negedge clk);
    chk(!done && scl && !tick, "R1", "aborted compute idle", {done, scl}, 2'b01);
    run_case(100, 200);
    run_case(3000, 0);
    chk(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule